// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block serves three 8-line general-purpose I/O ports, called A, B and F, from one simple register bus. Each port holds an output value, a per-line output enable and a set of per-line interrupt controls. These controls pick level or edge triggering and the active polarity. Each line can also be enabled and can have an optional input debounce filter. Edge events are latched until software clears them with a one-hot write to the port's clear register. Level events follow the pin and are not latched.

Every input pin passes through a two-flop synchronizer. When a line's filter is on, a new level is accepted only after it has been seen on four consecutive ticks of a slow sample strobe supplied from outside. Ports A and B drive one shared interrupt request. Each port F line drives a request output of its own.

The bus is a plain valid/write/address/data interface. Writes take effect at the clock edge. Read data is a combinational function of the address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register is zero: all pins are inputs (`pin_oe` = 0), `pin_out` = 0, all lines are level-low type and disabled, no status bit is set, and `irq_ab` and `irq_f` are 0.
- R2: Address bits [7:6] must be 0, bits [5:4] select the port (0 = A, 1 = B, 2 = F, 3 = none) and bits [3:0] select the register: 0 output value, 1 direction, 2 trigger kind, 3 polarity, 4 enable, 5 debounce, 6 clear (write only, reads 0), 7 status (read only). A direction bit of 1 drives the pin with its output bit. Reading register 0 returns the output bit for output lines and the synchronized pin for input lines. Writes to any other address change nothing.
- R3: With its kind bit at 0 (level), an enabled line is pending while its synchronized input equals its polarity bit (1 = high, 0 = low). The status follows the pin, and a clear write has no lasting effect on it.
- R4: With its kind bit at 1 (edge), an enabled line latches a pending event on a rising edge when its polarity bit is 1 and on a falling edge when it is 0. An edge of the other direction does not set it.
- R5: Writing a byte to a port's clear register (offset 6) clears the latched edge event of exactly the lines whose bit is 1 and leaves the others latched.
- R6: A line with its enable bit at 0 never raises a request and reads 0 in status. An edge that arrives while it is disabled is not latched, and disabling a line discards an event it had latched.
- R7: With its debounce bit set, a line accepts a new input level only after that level has been sampled on 4 consecutive `sample_tick` pulses. A shorter excursion is ignored. A line without debounce reacts two clock edges after its pin changes.
- R8: `irq_ab` is the OR of all status bits of ports A and B, and `irq_f[n]` equals status bit n of port F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| sample_tick | input | 1 | Slow strobe for the debounce filters |
| pin_in | input | 24 | Pin levels: [7:0] A, [15:8] B, [23:16] F |
| pin_out | output | 24 | Output values, same order |
| pin_oe | output | 24 | Output enables, same order |
| irq_ab | output | 1 | Shared request of ports A and B |
| irq_f | output | 8 | One request per port F line |

## Verification
A lost or stuck edge latch shows as a status bit or request line that stays wrong until the next clear write or enable change, so it is caught on the very next status read after the stimulus. A filter counter that fails to restart on a glitch lets a short pulse through at the fourth tick, and the port F request output shows it within one clock of that tick. A synchronizer or edge-history register with the wrong depth moves the reaction by a clock or produces a spurious edge at reset. Both show in the latched status once the line is enabled.

// File: rtl/gpio_irq_pkg.sv
// Shared constants and register selector codes for the GPIO interrupt block.
// Assumes a fixed set of three ports: A, B and F.
package gpio_irq_pkg;
    localparam int NPORTS = 3;

    typedef enum logic [3:0] {
        SEL_OUT   = 4'd0,
        SEL_DIR   = 4'd1,
        SEL_KIND  = 4'd2,
        SEL_POL   = 4'd3,
        SEL_EN    = 4'd4,
        SEL_DB    = 4'd5,
        SEL_CLR   = 4'd6,
        SEL_STAT  = 4'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_line.sv
// One interrupt-capable input line: two-flop synchronizer, tick-based
// debounce filter, edge detector, edge latch and pending decision.
// Assumes sample_tick is a single-cycle strobe and all config is static
// relative to one clock.
module gpio_line #(
    parameter int DB_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_tick,
    input  logic pin,
    input  logic db_en,
    input  logic kind,
    input  logic pol,
    input  logic en,
    input  logic clr,
    output logic sync_val,
    output logic flt_val,
    output logic pend
);
    localparam int CW = $clog2(DB_TICKS + 1);

    logic          meta;
    logic [CW-1:0] cnt;
    logic          prev;
    logic          latched;
    logic          qual;
    logic          hit;

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta     <= 1'b0;
            sync_val <= 1'b0;
        end else begin
            meta     <= pin;
            sync_val <= meta;
        end
    end

    // Accept a new level after DB_TICKS consecutive differing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_val <= 1'b0;
            cnt     <= '0;
        end else if (sample_tick) begin
            if (sync_val == flt_val) begin
                cnt <= '0;
            end else if (cnt == CW'(DB_TICKS - 1)) begin
                flt_val <= sync_val;
                cnt     <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign qual = db_en ? flt_val : sync_val;

    // Remember the qualified level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= qual;
    end

    assign hit = kind & (pol ? (qual & ~prev) : (~qual & prev));

    // Hold an edge event until cleared; a disabled line holds nothing.
    always_ff @(posedge clk) begin
        if (!rst_n)      latched <= 1'b0;
        else if (!en)    latched <= 1'b0;
        else if (hit)    latched <= 1'b1;
        else if (clr)    latched <= 1'b0;
    end

    assign pend = en & (kind ? latched : (qual == pol));
endmodule

// File: rtl/gpio_port.sv
// One GPIO port: configuration registers, a line instance per pin and the
// read-data selector. Assumes wr_en is already qualified for this port.
module gpio_port
    import gpio_irq_pkg::*;
#(
    parameter int LINES    = 8,
    parameter int DB_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic             wr_en,
    input  logic [3:0]       reg_sel,
    input  logic [LINES-1:0] wdata,
    input  logic [LINES-1:0] pins,
    output logic [LINES-1:0] rdata,
    output logic [LINES-1:0] out_q,
    output logic [LINES-1:0] oe_q,
    output logic [LINES-1:0] status,
    output logic [LINES-1:0] en_q,
    output logic [LINES-1:0] flt
);
    logic [LINES-1:0] kind_q;
    logic [LINES-1:0] pol_q;
    logic [LINES-1:0] db_q;
    logic [LINES-1:0] clr_vec;
    logic [LINES-1:0] sync_vec;

    // Store software-written configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            oe_q   <= '0;
            kind_q <= '0;
            pol_q  <= '0;
            en_q   <= '0;
            db_q   <= '0;
        end else if (wr_en) begin
            case (reg_sel)
                SEL_OUT:  out_q  <= wdata;
                SEL_DIR:  oe_q   <= wdata;
                SEL_KIND: kind_q <= wdata;
                SEL_POL:  pol_q  <= wdata;
                SEL_EN:   en_q   <= wdata;
                SEL_DB:   db_q   <= wdata;
                default:  ;
            endcase
        end
    end

    assign clr_vec = (wr_en && reg_sel == SEL_CLR) ? wdata : '0;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        gpio_line #(.DB_TICKS(DB_TICKS)) line_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .sample_tick (sample_tick),
            .pin         (pins[i]),
            .db_en       (db_q[i]),
            .kind        (kind_q[i]),
            .pol         (pol_q[i]),
            .en          (en_q[i]),
            .clr         (clr_vec[i]),
            .sync_val    (sync_vec[i]),
            .flt_val     (flt[i]),
            .pend        (status[i])
        );
    end

    // Select the register addressed by reg_sel for reading.
    always_comb begin
        case (reg_sel)
            SEL_OUT:  rdata = (oe_q & out_q) | (~oe_q & sync_vec);
            SEL_DIR:  rdata = oe_q;
            SEL_KIND: rdata = kind_q;
            SEL_POL:  rdata = pol_q;
            SEL_EN:   rdata = en_q;
            SEL_DB:   rdata = db_q;
            SEL_STAT: rdata = status;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top of the GPIO interrupt block: address decode over three ports and
// interrupt output combining (A and B shared, F one output per line).
// Assumes bus_addr[7:6] is zero for valid accesses.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int LINES    = 8,
    parameter int DB_TICKS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [7:0]         bus_addr,
    input  logic [LINES-1:0]   bus_wdata,
    output logic [LINES-1:0]   bus_rdata,
    input  logic               sample_tick,
    input  logic [3*LINES-1:0] pin_in,
    output logic [3*LINES-1:0] pin_out,
    output logic [3*LINES-1:0] pin_oe,
    output logic               irq_ab,
    output logic [LINES-1:0]   irq_f
);
    localparam int NPINS = NPORTS * LINES;

    logic                          in_range;
    logic [1:0]                    port_id;
    logic [NPORTS-1:0][LINES-1:0]  rd_p;
    logic [NPINS-1:0]              en_all;
    logic [NPINS-1:0]              stat_all;
    logic [NPINS-1:0]              flt_all;

    assign in_range = (bus_addr[7:6] == 2'b00);
    assign port_id  = bus_addr[5:4];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic wr_here;
        assign wr_here = bus_valid & bus_write & in_range & (port_id == 2'(p));

        gpio_port #(.LINES(LINES), .DB_TICKS(DB_TICKS)) port_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .sample_tick (sample_tick),
            .wr_en       (wr_here),
            .reg_sel     (bus_addr[3:0]),
            .wdata       (bus_wdata),
            .pins        (pin_in[p*LINES +: LINES]),
            .rdata       (rd_p[p]),
            .out_q       (pin_out[p*LINES +: LINES]),
            .oe_q        (pin_oe[p*LINES +: LINES]),
            .status      (stat_all[p*LINES +: LINES]),
            .en_q        (en_all[p*LINES +: LINES]),
            .flt         (flt_all[p*LINES +: LINES])
        );
    end

    // Return the addressed port's data; unmapped space reads zero.
    always_comb begin
        bus_rdata = '0;
        if (in_range) begin
            case (port_id)
                2'd0:    bus_rdata = rd_p[0];
                2'd1:    bus_rdata = rd_p[1];
                2'd2:    bus_rdata = rd_p[2];
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq_ab = |stat_all[2*LINES-1:0];
    assign irq_f  = stat_all[3*LINES-1:2*LINES];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Property checker for gpio_irq_ctrl, attached by bind. Observes ports and
// the per-line enable, status and filter vectors of the top.
module gpio_irq_ctrl_chk #(
    parameter int LINES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [7:0]         bus_addr,
    input logic [LINES-1:0]   bus_wdata,
    input logic               sample_tick,
    input logic [3*LINES-1:0] pin_out,
    input logic [3*LINES-1:0] pin_oe,
    input logic               irq_ab,
    input logic [LINES-1:0]   irq_f,
    input logic [3*LINES-1:0] en_all,
    input logic [3*LINES-1:0] stat_all,
    input logic [3*LINES-1:0] flt_all
);
    // R1: first cycle out of reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq_ab && irq_f == '0 && pin_oe == '0));

    // R2: a write to port A direction lands on pin_oe next cycle
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 8'h01) |=> pin_oe[LINES-1:0] == $past(bus_wdata));

    // R2: a write to port F output value lands on pin_out next cycle
    a_r2_out_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 8'h20) |=> pin_out[3*LINES-1:2*LINES] == $past(bus_wdata));

    // R6: a disabled line never shows status
    a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_all & ~en_all) == '0);

    // R7: filtered levels move only on a sample tick
    a_r7_filter_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> $stable(flt_all));

    // R8: the shared request needs some enabled A/B line
    a_r8_ab_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ab |-> (en_all[2*LINES-1:0] != '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.LINES(LINES)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .sample_tick (sample_tick),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .irq_ab      (irq_ab),
    .irq_f       (irq_f),
    .en_all      (en_all),
    .stat_all    (stat_all),
    .flt_all     (flt_all)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        sample_tick = 1'b0;
    logic [23:0] pin_in = 24'h0;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;
    logic        irq_ab;
    logic [7:0]  irq_f;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_ctrl dut_i (
        .clk (clk), .rst_n (rst_n), .bus_valid (bus_valid), .bus_write (bus_write),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .sample_tick (sample_tick), .pin_in (pin_in), .pin_out (pin_out),
        .pin_oe (pin_oe), .irq_ab (irq_ab), .irq_f (irq_f)
    );

    // {write, addr, wdata, expected read}
    localparam logic [24:0] VEC [16] = '{
        {1'b1, 8'h01, 8'hF0, 8'h00}, {1'b0, 8'h01, 8'h00, 8'hF0},
        {1'b1, 8'h00, 8'hA5, 8'h00}, {1'b0, 8'h00, 8'h00, 8'hA0},
        {1'b1, 8'h12, 8'h3C, 8'h00}, {1'b0, 8'h12, 8'h00, 8'h3C},
        {1'b1, 8'h23, 8'h81, 8'h00}, {1'b0, 8'h23, 8'h00, 8'h81},
        {1'b1, 8'h15, 8'h0F, 8'h00}, {1'b0, 8'h15, 8'h00, 8'h0F},
        {1'b1, 8'h26, 8'hFF, 8'h00}, {1'b0, 8'h26, 8'h00, 8'h00},
        {1'b1, 8'h30, 8'hFF, 8'h00}, {1'b0, 8'h30, 8'h00, 8'h00},
        {1'b1, 8'h41, 8'hFF, 8'h00}, {1'b0, 8'h01, 8'h00, 8'hF0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_valid = 1'b1; bus_write = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_valid = 1'b1; bus_write = 1'b0;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) sample_tick = 1'b1;
        @(negedge clk) sample_tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        settle(3);
        rst_n = 1'b1;
        settle(1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        do_reset();

        // R2: register map walk
        for (int i = 0; i < 16; i++) begin
            if (VEC[i][24]) wr(VEC[i][23:16], VEC[i][15:8]);
            else begin
                rd(VEC[i][23:16], d);
                check("R2 table", d, VEC[i][7:0]);
            end
        end
        check("R2 pin_out A", pin_out[7:0], 8'hA5);

        // R1: reset clears everything
        do_reset();
        check("R1 pin_oe A", pin_oe[7:0], 8'h00);
        check("R1 pin_oe F", pin_oe[23:16], 8'h00);
        check("R1 pin_out A", pin_out[7:0], 8'h00);
        check("R1 irq_ab", {7'd0, irq_ab}, 8'h00);
        check("R1 irq_f", irq_f, 8'h00);
        rd(8'h12, d); check("R1 kind B", d, 8'h00);
        rd(8'h07, d); check("R1 status A", d, 8'h00);

        // R2: direction and output value on port F, input readback on A
        wr(8'h21, 8'h0F);
        check("R2 pin_oe F", pin_oe[23:16], 8'h0F);
        wr(8'h20, 8'h55);
        check("R2 pin_out F", pin_out[23:16], 8'h55);
        rd(8'h20, d); check("R2 readback F", d, 8'h05);
        pin_in[7:0] = 8'h3C; settle(3);
        rd(8'h00, d); check("R2 input read A", d, 8'h3C);

        // R3: level mode on port A
        pin_in[7:0] = 8'h00; settle(3);
        wr(8'h03, 8'h01); wr(8'h04, 8'h03);
        settle(1);
        rd(8'h07, d); check("R3 level low active", d, 8'h02);
        check("R8 irq_ab from A", {7'd0, irq_ab}, 8'h01);
        pin_in[7:0] = 8'h01; settle(3);
        rd(8'h07, d); check("R3 both active", d, 8'h03);
        wr(8'h06, 8'hFF); settle(1);
        rd(8'h07, d); check("R3 clear no effect", d, 8'h03);
        pin_in[7:0] = 8'h02; settle(3);
        rd(8'h07, d); check("R3 both inactive", d, 8'h00);
        check("R3 irq_ab low", {7'd0, irq_ab}, 8'h00);
        wr(8'h04, 8'h00);

        // R4: edge mode on port B (line0 rising, line1 falling)
        pin_in[15:8] = 8'h02; settle(4);
        wr(8'h12, 8'h03); wr(8'h13, 8'h01); wr(8'h14, 8'h03);
        settle(2);
        rd(8'h17, d); check("R4 no edge yet", d, 8'h00);
        pin_in[15:8] = 8'h03; settle(4);
        rd(8'h17, d); check("R4 rising latched", d, 8'h01);
        check("R8 irq_ab from B", {7'd0, irq_ab}, 8'h01);
        pin_in[15:8] = 8'h02; settle(4);
        rd(8'h17, d); check("R4 falling on rising line", d, 8'h01);
        pin_in[15:8] = 8'h00; settle(4);
        rd(8'h17, d); check("R4 falling latched", d, 8'h03);

        // R5: one-hot clear
        wr(8'h16, 8'h01); settle(1);
        rd(8'h17, d); check("R5 clear line0 only", d, 8'h02);
        check("R5 irq_ab still set", {7'd0, irq_ab}, 8'h01);
        wr(8'h16, 8'h02); settle(1);
        rd(8'h17, d); check("R5 clear line1", d, 8'h00);
        check("R5 irq_ab low", {7'd0, irq_ab}, 8'h00);

        // R6: disabled lines
        wr(8'h14, 8'h01);
        pin_in[15:8] = 8'h02; settle(4);
        pin_in[15:8] = 8'h00; settle(4);
        wr(8'h14, 8'h03); settle(1);
        rd(8'h17, d); check("R6 edge while disabled", d, 8'h00);
        pin_in[15:8] = 8'h01; settle(4);
        rd(8'h17, d); check("R6 setup latch", d, 8'h01);
        wr(8'h14, 8'h02); settle(1);
        rd(8'h17, d); check("R6 disabled reads 0", d, 8'h00);
        check("R6 irq_ab off", {7'd0, irq_ab}, 8'h00);
        wr(8'h14, 8'h03); settle(1);
        rd(8'h17, d); check("R6 latch discarded", d, 8'h00);

        // R7: debounce on port F line0, line1 undebounced
        wr(8'h22, 8'h00); wr(8'h23, 8'h03); wr(8'h25, 8'h01); wr(8'h24, 8'h03);
        pin_in[17:16] = 2'b11; settle(3);
        check("R7 undebounced line immediate", irq_f, 8'h02);
        tick(); tick(); tick(); settle(1);
        check("R7 three ticks not enough", irq_f, 8'h02);
        tick(); settle(1);
        check("R7 fourth tick passes", irq_f, 8'h03);
        check("R8 irq_ab unaffected by F", {7'd0, irq_ab}, 8'h00);
        pin_in[16] = 1'b0; settle(3);
        tick(); tick();
        pin_in[16] = 1'b1; settle(3);
        tick(); tick(); tick(); settle(1);
        check("R7 glitch ignored", irq_f, 8'h03);

        done = 1'b1;
        finish_run();
    end
endmodule